// File: doc/BRIEF.md
# Non-Overlapping Pulse Pattern Generator

This block drives an 8-bit pin vector from a pattern held in a double buffer. A counter runs on a prescaled clock and is compared against two values. The period value sets the output update interval, and the counter clears when it reaches that value. The margin value sets a point inside the period. Software writes the next pattern into a staging register. At each period event, the enabled pins take their levels from that staging register. An interrupt line rises at the margin point to ask for the following pattern.

The pins are split into two groups of four. Each group can be placed in non-overlapping mode. In that mode a group splits its update into two parts. Bits that fall are applied at the period event. Bits that rise are held back until the margin event. This leaves a dead gap, so complementary phases, such as a four-phase drive, never overlap. Groups in normal mode apply all of their bits at the period event.

The output register can also be written directly to set the starting pin levels. The counter does not advance until the run bit is set.

Top module: `pgen_top`

## Requirements
- R1: A synchronous reset clears the pins and the interrupt line to 0 and leaves the counter stopped.
- R2: While the run bit (bit 4 of the control register at address 0) is 0, the pins do not change, except through a direct output write.
- R3: A counter tick occurs every 2^sel clock cycles while running, where sel is bits 1:0 of the control register. The counter clears on the tick where it has reached the period value (address 1), so one period lasts (period+1) ticks.
- R4: At a period event, each pin whose enable bit (address 5) is 1 in a normal-mode group takes its bit from the staging register (address 3). Pins whose enable bit is 0 keep their level.
- R5: A write to the output register (address 4) sets the pins to the written value on the next clock and cancels any pending rising bits.
- R6: In a non-overlapping group, with margin (address 2) less than period, enabled bits going 1 to 0 fall at the period event. Enabled bits going 0 to 1 rise at the following margin event, which is the tick where the counter equals the margin value. No bit falls at a margin event.
- R7: In a non-overlapping group whose margin is not less than the period, rising bits are applied at the period event with no gap.
- R8: The interrupt line is set on the tick where the counter equals the margin value. It is cleared by a write to the staging register, and setting takes priority over clearing.
- R9: The mode register (address 6, bit g for group g, where group g is pins 4g+3..4g) selects non-overlapping mode for each group independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pins_o | output | 8 | Pattern output pins (registered) |
| irq_o | output | 1 | Next-pattern request (registered) |

## Verification
The bench rotates a four-phase pattern through groups in non-overlapping mode. A design that applied rising bits at the period event would show two adjacent phases high at once. A design that delayed falling bits would hold an old phase through the gap. Margins equal to or larger than the period check the fallback path. There, a design that still waited for a margin event would never raise the bits. Mixed-mode and partly enabled runs show whether a design leaks the split update into a normal group or updates masked pins. Every prescale setting is used, so a design that is off by one tick in the period length drifts from the reference model within a few periods.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  localparam int ADDR_W  = 3;
  localparam int SEL_W   = 2;
  localparam int RUN_BIT = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_PERIOD = 3'd1,
    A_MARGIN = 3'd2,
    A_NEXT   = 3'd3,
    A_OUT    = 3'd4,
    A_PINEN  = 3'd5,
    A_MODE   = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/pgen_regs.sv
module pgen_regs
  import pgen_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PIN_W = 8,
  parameter int N_GRP = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CNT_W-1:0]   wr_data,
  output logic               run,
  output logic [SEL_W-1:0]   sel,
  output logic [CNT_W-1:0]   period,
  output logic [CNT_W-1:0]   margin,
  output logic [PIN_W-1:0]   nxt,
  output logic [PIN_W-1:0]   pin_en,
  output logic [N_GRP-1:0]   novl,
  output logic               wr_out,
  output logic               wr_next,
  output logic [PIN_W-1:0]   out_val
);
  assign wr_out  = wr_en && (wr_addr == A_OUT);
  assign wr_next = wr_en && (wr_addr == A_NEXT);
  assign out_val = wr_data[PIN_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      sel    <= '0;
      period <= '0;
      margin <= '0;
      nxt    <= '0;
      pin_en <= '0;
      novl   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          run <= wr_data[RUN_BIT];
          sel <= wr_data[SEL_W-1:0];
        end
        A_PERIOD: period <= wr_data;
        A_MARGIN: margin <= wr_data;
        A_NEXT:   nxt    <= wr_data[PIN_W-1:0];
        A_PINEN:  pin_en <= wr_data[PIN_W-1:0];
        A_MODE:   novl   <= wr_data[N_GRP-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pgen_timebase.sv
module pgen_timebase
  import pgen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] margin,
  output logic             per_hit,
  output logic             cmpa_hit,
  output logic             rise_ok
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] mask;
  logic [CNT_W-1:0] cnt;
  logic             tick;

  assign mask     = ~({PRE_W{1'b1}} << sel);
  assign tick     = run && ((pre_cnt & mask) == mask);
  assign per_hit  = tick && (cnt >= period);
  assign cmpa_hit = tick && (cnt == margin);
  assign rise_ok  = margin < period;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      cnt     <= '0;
    end else begin
      if (run) pre_cnt <= pre_cnt + 1'b1;
      if (tick) cnt <= per_hit ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pgen_outstage.sv
module pgen_outstage #(
  parameter int GRP_W = 4,
  parameter int N_GRP = 2,
  localparam int PIN_W = GRP_W * N_GRP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             per_hit,
  input  logic             rise_hit,
  input  logic             rise_ok,
  input  logic [PIN_W-1:0] nxt,
  input  logic [PIN_W-1:0] pin_en,
  input  logic [N_GRP-1:0] novl,
  input  logic             wr_out,
  input  logic [PIN_W-1:0] out_val,
  output logic [PIN_W-1:0] pins
);
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic [GRP_W-1:0] od, pend, nd, en;
    assign nd = nxt[g*GRP_W +: GRP_W];
    assign en = pin_en[g*GRP_W +: GRP_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        od   <= '0;
        pend <= '0;
      end else if (wr_out) begin
        od   <= out_val[g*GRP_W +: GRP_W];
        pend <= '0;
      end else if (per_hit) begin
        if (novl[g] && rise_ok) begin
          od   <= od & ~(en & ~nd);
          pend <= en & nd & ~od;
        end else begin
          od   <= (od & ~en) | (nd & en);
          pend <= '0;
        end
      end else if (rise_hit) begin
        od   <= od | pend;
        pend <= '0;
      end
    end

    assign pins[g*GRP_W +: GRP_W] = od;
  end
endmodule

// File: rtl/pgen_top.sv
module pgen_top
  import pgen_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int GRP_W = 4,
  parameter int N_GRP = 2,
  localparam int PIN_W = GRP_W * N_GRP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [PIN_W-1:0]  pins_o,
  output logic              irq_o
);
  logic             run, wr_out, wr_next;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] period, margin;
  logic [PIN_W-1:0] nxt, pin_en, out_val;
  logic [N_GRP-1:0] novl;
  logic             per_hit, cmpa_hit, rise_ok, rise_hit;

  pgen_regs #(.CNT_W(CNT_W), .PIN_W(PIN_W), .N_GRP(N_GRP)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run(run), .sel(sel), .period(period), .margin(margin), .nxt(nxt),
    .pin_en(pin_en), .novl(novl), .wr_out(wr_out), .wr_next(wr_next),
    .out_val(out_val)
  );

  pgen_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst(rst), .run(run), .sel(sel), .period(period),
    .margin(margin), .per_hit(per_hit), .cmpa_hit(cmpa_hit), .rise_ok(rise_ok)
  );

  assign rise_hit = cmpa_hit && rise_ok;

  pgen_outstage #(.GRP_W(GRP_W), .N_GRP(N_GRP)) u_out (
    .clk(clk), .rst(rst), .per_hit(per_hit), .rise_hit(rise_hit),
    .rise_ok(rise_ok), .nxt(nxt), .pin_en(pin_en), .novl(novl),
    .wr_out(wr_out), .out_val(out_val), .pins(pins_o)
  );

  always_ff @(posedge clk) begin
    if (rst)           irq_o <= 1'b0;
    else if (cmpa_hit) irq_o <= 1'b1;
    else if (wr_next)  irq_o <= 1'b0;
  end
endmodule

// File: rtl/pgen_sva.sv
module pgen_sva #(
  parameter int PIN_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_out,
  input logic             wr_next,
  input logic             run,
  input logic             per_hit,
  input logic             cmpa_hit,
  input logic             rise_hit,
  input logic [PIN_W-1:0] pins_o,
  input logic             irq_o
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (pins_o == '0) && !irq_o); // R1
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !run && !wr_out |=> $stable(pins_o)); // R2
  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (rst)
    !per_hit && !rise_hit && !wr_out |=> $stable(pins_o)); // R4
  AST_RISE_NO_FALL: assert property (@(posedge clk) disable iff (rst)
    rise_hit && !wr_out |=> (($past(pins_o) & ~pins_o) == '0)); // R6
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst) cmpa_hit |=> irq_o); // R8
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    wr_next && !cmpa_hit |=> !irq_o); // R8
endmodule

bind pgen_top pgen_sva #(.PIN_W(PIN_W)) u_sva (
  .clk(clk), .rst(rst), .wr_out(wr_out), .wr_next(wr_next), .run(run),
  .per_hit(per_hit), .cmpa_hit(cmpa_hit), .rise_hit(rise_hit),
  .pins_o(pins_o), .irq_o(irq_o)
);

// File: tb/test_pgen_top.sv
module test_pgen_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  pins_o;
  logic        irq_o;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0, started = 0;
  string cur_req = "R1";

  int m_run, m_sel, m_per, m_mar, m_nd, m_en, m_mode, m_od, m_pend, m_irq, m_pc, m_cnt;
  int mask, tick, phit, ahit, rok, n_od, n_pend, nb, ob, idx;

  always #2.5 clk = ~clk;

  pgen_top i_pgen_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pins_o(pins_o), .irq_o(irq_o)
  );

  // behavioural reference model
  always @(posedge clk) begin
    cycles++;
    started = 1;
    if (rst) begin
      m_run = 0; m_sel = 0; m_per = 0; m_mar = 0; m_nd = 0; m_en = 0; m_mode = 0;
      m_od = 0; m_pend = 0; m_irq = 0; m_pc = 0; m_cnt = 0;
    end else begin
      mask = (1 << m_sel) - 1;
      tick = (m_run != 0) && ((m_pc & mask) == mask);
      phit = tick && (m_cnt >= m_per);
      ahit = tick && (m_cnt == m_mar);
      rok  = m_mar < m_per;
      n_od = m_od; n_pend = m_pend;
      if (wr_en && wr_addr == 3'd4) begin
        n_od = wr_data & 255; n_pend = 0;
      end else if (phit) begin
        n_pend = 0;
        for (int i = 0; i < 8; i++) begin
          if ((m_en >> i) & 1) begin
            nb = (m_nd >> i) & 1; ob = (m_od >> i) & 1;
            if (((m_mode >> (i / 4)) & 1) && rok) begin
              if (nb == 0) n_od = n_od & ~(1 << i);
              else if (ob == 0) n_pend = n_pend | (1 << i);
            end else begin
              n_od = nb ? (n_od | (1 << i)) : (n_od & ~(1 << i));
            end
          end
        end
      end else if (ahit && rok) begin
        n_od = n_od | m_pend; n_pend = 0;
      end
      if (ahit) m_irq = 1;
      else if (wr_en && wr_addr == 3'd3) m_irq = 0;
      if (m_run) m_pc = (m_pc + 1) & 7;
      if (tick) m_cnt = phit ? 0 : ((m_cnt + 1) & 65535);
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_run = (wr_data >> 4) & 1; m_sel = wr_data & 3; end
          3'd1: m_per = wr_data;
          3'd2: m_mar = wr_data;
          3'd3: m_nd = wr_data & 255;
          3'd5: m_en = wr_data & 255;
          3'd6: m_mode = wr_data & 3;
          default: ;
        endcase
      end
      m_od = n_od; m_pend = n_pend;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      total++;
      if (pins_o !== 8'(m_od) || irq_o !== 1'(m_irq)) begin
        bad++;
        $display("FAIL %s cycle %0d: pins=%h irq=%b expected pins=%h irq=%0d",
                 cur_req, cycles, pins_o, irq_o, 8'(m_od), m_irq);
      end
    end
  end

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_irq();
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (irq_o) break;
    end
  endtask

  task automatic run_phases(input int n);
    logic [7:0] pat [4];
    pat[0] = 8'h11; pat[1] = 8'h22; pat[2] = 8'h44; pat[3] = 8'h88;
    for (int k = 0; k < n; k++) begin
      wait_irq();
      wr(3'd3, {8'h00, pat[k % 4]});
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    idle(4);
    cur_req = "R1";
    @(negedge clk);
    check("R1 pins", pins_o, 8'h00);
    check("R1 irq", {7'b0, irq_o}, 8'h00);
    rst = 1'b0;
    #1;

    cur_req = "R2";
    wr(3'd1, 16'd2); wr(3'd2, 16'd1); wr(3'd5, 16'hFF); wr(3'd3, 16'hFF);
    idle(20);
    @(negedge clk);
    check("R2 stopped", pins_o, 8'h00);

    cur_req = "R5";
    wr(3'd4, 16'h5A);
    @(negedge clk);
    check("R5 direct", pins_o, 8'h5A);

    cur_req = "R4";
    wr(3'd1, 16'd3); wr(3'd3, 16'h3C); wr(3'd0, 16'h10);
    idle(20);
    wr(3'd5, 16'h0F); wr(3'd3, 16'hF0);
    idle(20);
    cur_req = "R3";
    wr(3'd0, 16'h12); idle(60);
    wr(3'd0, 16'h13); wr(3'd3, 16'h0A); idle(100);
    wr(3'd0, 16'h11); idle(40);

    cur_req = "R6";
    wr(3'd0, 16'h00); wr(3'd4, 16'h88); wr(3'd5, 16'hFF); wr(3'd6, 16'h3);
    wr(3'd1, 16'd9); wr(3'd2, 16'd3); wr(3'd0, 16'h11);
    run_phases(10);

    cur_req = "R9";
    wr(3'd6, 16'h1); run_phases(6);
    wr(3'd6, 16'h2); run_phases(6);

    cur_req = "R7";
    wr(3'd6, 16'h3); wr(3'd0, 16'h10); wr(3'd1, 16'd5); wr(3'd2, 16'd9);
    wr(3'd3, 16'h33); idle(20); wr(3'd3, 16'hCC); idle(20);
    wr(3'd2, 16'd5); run_phases(5);

    cur_req = "R8";
    wr(3'd2, 16'd2); wait_irq(); idle(8);
    @(negedge clk);
    check("R8 irq held", {7'b0, irq_o}, 8'h01);
    wr(3'd3, 16'h55);
    @(negedge clk);
    check("R8 irq cleared", {7'b0, irq_o}, 8'h00);

    cur_req = "R5";
    wr(3'd4, 16'hC3);
    @(negedge clk);
    check("R5 direct running", pins_o, 8'hC3);
    idle(30);
    finish_run();
  end

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
    end
  end
endmodule